// File: doc/BRIEF.md
# Exact-Match Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame is kept. It compares the 6-byte destination address against a table of 16 stored station addresses. A frame is kept when its address equals any table entry. A pass-all input keeps every frame regardless of the table.

The table is never written through registers. It is loaded from a 192-byte setup frame delivered as a byte stream, made of 16 slots of 12 bytes. Inside a slot, each two-byte half of an address is sent twice in a row, so a slot carries the bytes x0 x1 x0 x1 x2 x3 x2 x3 x4 x5 x4 x5. Only the first copy of each pair is kept.

Software normally fills unused slots with the station's own address and puts all-ones in one slot so that broadcast frames are kept. The new table replaces the old one only when a setup frame is complete. The destination address arrives as a separate byte stream, first byte first, and one result pulse follows each address.

Top module: `exact_dest_filter`

## Requirements
- R1: After reset, `res_valid` is low and every address is rejected until a complete setup frame has been loaded, unless `pass_all` is high.
- R2: Once a complete 192-byte setup frame has been taken in, any destination address equal to one of its 16 entries is accepted, including an all-ones entry.
- R3: In slot position p (0 to 11, counted from the slot's first byte), only positions 0, 1, 4, 5, 8 and 9 supply address bytes 0 to 5 in that order. Positions 2, 3, 6, 7, 10 and 11 have no effect on the table.
- R4: `res_valid` pulses high for exactly one cycle, in the cycle after the sixth address byte is taken, and stays low while the earlier bytes arrive.
- R5: An address that differs from every table entry in any bit is rejected when `pass_all` is low.
- R6: A setup frame cut short by a new `cfg_start` before its 192nd byte is discarded, and the previously loaded table keeps deciding.
- R7: Setup bytes marked valid after the 192nd byte and before the next `cfg_start` are ignored.
- R8: When `pass_all` is high in the cycle of the sixth address byte, the result is accept.
- R9: Address bytes after the sixth are ignored until the next `da_start`. A `da_start` in the middle of an address restarts capture from that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_all | input | 1 | Accept every frame |
| cfg_start | input | 1 | Marks the first byte of a setup frame (with cfg_valid) |
| cfg_valid | input | 1 | Setup byte strobe |
| cfg_byte | input | 8 | Setup frame byte |
| da_start | input | 1 | Marks the first destination address byte (with da_valid) |
| da_valid | input | 1 | Address byte strobe |
| da_byte | input | 8 | Destination address byte, first byte first |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame accepted, qualified by res_valid |

## Verification
The checks assume that `cfg_start` and `da_start` only ever come together with their valid strobes. They also assume that the input streams are quiet during reset, so the first sampled history after reset is idle. The stimulus follows both rules. Each byte, start and pass-all value is driven on the falling edge and held for one full cycle. Address streams are at least six cycles apart, so two result pulses never touch.

// File: rtl/exact_dest_filter.sv
`timescale 1ns/1ps
module exact_dest_filter #(
  parameter int ENTRIES    = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pass_all,
  input  logic       cfg_start,
  input  logic       cfg_valid,
  input  logic [7:0] cfg_byte,
  input  logic       da_start,
  input  logic       da_valid,
  input  logic [7:0] da_byte,
  output logic       res_valid,
  output logic       res_accept
);
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int SLOT_BYTES = 2 * ADDR_BYTES;
  localparam int SW         = $clog2(ENTRIES);
  localparam int PW         = $clog2(SLOT_BYTES);
  localparam int DW         = $clog2(ADDR_BYTES);

  logic [ADDR_W-1:0] shadow  [ENTRIES];
  logic [ADDR_W-1:0] table_q [ENTRIES];
  logic              tbl_loaded;

  logic          cfg_busy;
  logic [SW-1:0] slot_q;
  logic [PW-1:0] pos_q;

  wire           cfg_take = cfg_valid && (cfg_start || cfg_busy);
  wire [SW-1:0]  slot_w   = cfg_start ? '0 : slot_q;
  wire [PW-1:0]  pos_w    = cfg_start ? '0 : pos_q;
  wire           pos_used = ~pos_w[1];
  wire [PW-1:0]  bidx     = {1'b0, pos_w[PW-1:2], pos_w[0]};
  wire           last_pos = (pos_w == PW'(SLOT_BYTES - 1));
  wire           commit   = cfg_take && last_pos && (slot_w == SW'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (cfg_take && pos_used)
      for (int b = 0; b < ADDR_BYTES; b++)
        if (bidx == PW'(b)) shadow[slot_w][ADDR_W-1-8*b -: 8] <= cfg_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_busy   <= 1'b0;
      slot_q     <= '0;
      pos_q      <= '0;
      tbl_loaded <= 1'b0;
      for (int e = 0; e < ENTRIES; e++) table_q[e] <= '0;
    end else if (cfg_take) begin
      cfg_busy <= !commit;
      pos_q    <= last_pos ? '0 : pos_w + 1'b1;
      slot_q   <= last_pos ? slot_w + 1'b1 : slot_w;
      if (commit) begin
        tbl_loaded <= 1'b1;
        for (int e = 0; e < ENTRIES; e++) table_q[e] <= shadow[e];
      end
    end
  end

  logic                da_busy;
  logic [DW-1:0]       dcnt;
  logic [ADDR_W-9:0]   acc;
  logic [ENTRIES-1:0]  hit;

  wire              da_take   = da_valid && (da_start || da_busy);
  wire [DW-1:0]     dcnt_w    = da_start ? '0 : dcnt;
  wire              da_last   = (dcnt_w == DW'(ADDR_BYTES - 1));
  wire [ADDR_W-1:0] full_addr = {acc, da_byte};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = (table_q[i] == full_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da_busy    <= 1'b0;
      dcnt       <= '0;
      acc        <= '0;
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_valid  <= da_take && da_last;
      res_accept <= da_take && da_last && (pass_all || (tbl_loaded && |hit));
      if (da_take) begin
        da_busy <= !da_last;
        dcnt    <= dcnt_w + 1'b1;
        acc     <= full_addr[ADDR_W-9:0];
      end
    end
  end
endmodule

// File: rtl/exact_dest_filter_chk.sv
`timescale 1ns/1ps
module exact_dest_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic pass_all,
  input logic cfg_start,
  input logic cfg_valid,
  input logic da_valid,
  input logic res_valid,
  input logic res_accept,
  input logic loaded
);
  // R4
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R4
  res_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(da_valid));
  // R1
  empty_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(pass_all) && !loaded) |-> !res_accept);
  // R8
  pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(pass_all)) |-> res_accept);
  // R2
  load_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(cfg_valid && !cfg_start));
  // R4
  accept_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> res_valid);
endmodule

bind exact_dest_filter exact_dest_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pass_all(pass_all),
  .cfg_start(cfg_start), .cfg_valid(cfg_valid), .da_valid(da_valid),
  .res_valid(res_valid), .res_accept(res_accept), .loaded(tbl_loaded)
);

// File: tb/exact_dest_filter_bench.sv
`timescale 1ns/1ps
module exact_dest_filter_bench;
  logic clk = 0;
  always #5 clk = ~clk;

  logic       rst_n = 0, pass_all = 0;
  logic       cfg_start = 0, cfg_valid = 0, da_start = 0, da_valid = 0;
  logic [7:0] cfg_byte = 0, da_byte = 0;
  logic       res_valid, res_accept;

  exact_dest_filter u_exact_dest_filter (
    .clk(clk), .rst_n(rst_n), .pass_all(pass_all),
    .cfg_start(cfg_start), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
    .da_start(da_start), .da_valid(da_valid), .da_byte(da_byte),
    .res_valid(res_valid), .res_accept(res_accept)
  );

  int checks = 0, errors = 0;
  int cur_tbl = 0;
  bit mdl_loaded = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] addr_of(input int t, input int k);
    logic [7:0] kb;
    kb = 8'(k);
    if (k == 15) return 48'hFFFF_FFFF_FFFF;
    return {8'h02, 8'(t), kb, 8'(kb * 3), kb ^ 8'h55, 8'h10 + kb};
  endfunction

  function automatic logic [7:0] setup_byte(input int t, input int idx);
    int s, p, b;
    logic [47:0] a;
    s = idx / 12; p = idx % 12;
    if (p[1]) return 8'hA5 ^ 8'(idx);
    b = (p >> 2) * 2 + p[0];
    a = addr_of(t, s);
    return a[47 - 8*b -: 8];
  endfunction

  function automatic bit exp_acc(input logic [47:0] a, input bit pa);
    if (pa) return 1;
    if (!mdl_loaded) return 0;
    for (int k = 0; k < 16; k++) if (addr_of(cur_tbl, k) == a) return 1;
    return 0;
  endfunction

  task automatic send_setup(input int t, input int n, input int xt, input int xn);
    for (int i = 0; i < n + xn; i++) begin
      @(negedge clk);
      cfg_valid = 1;
      cfg_start = (i == 0);
      cfg_byte  = (i < n) ? setup_byte(t, i) : setup_byte(xt, i - n);
    end
    @(negedge clk);
    cfg_valid = 0; cfg_start = 0;
    if (n == 192) begin cur_tbl = t; mdl_loaded = 1; end
  endtask

  task automatic query(input logic [47:0] a, input bit pa, input string req, input int extra);
    bit e;
    e = exp_acc(a, pa);
    pass_all = pa;
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      if (b == 5) chk(res_valid == 0, "R4", "early res_valid", res_valid, 0);
      da_valid = 1; da_start = (b == 0); da_byte = a[47 - 8*b -: 8];
    end
    @(negedge clk);
    da_valid = 0; da_start = 0;
    chk(res_valid == 1, "R4", "res_valid after sixth byte", res_valid, 1);
    chk(res_accept == e, req, $sformatf("accept for %012h", a), res_accept, e);
    for (int x = 0; x < extra; x++) begin
      da_valid = 1; da_byte = 8'(x + 1);
      @(negedge clk);
      chk(res_valid == 0, "R9", "result after extra byte", res_valid, 0);
    end
    da_valid = 0;
    @(negedge clk);
    pass_all = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0, "R1", "res_valid after reset", res_valid, 0);
    query(addr_of(1, 3), 0, "R1", 0);
    query(48'h0, 0, "R1", 0);
    query(addr_of(1, 3), 1, "R8", 0);

    send_setup(1, 192, 0, 0);
    for (int k = 0; k < 16; k++) query(addr_of(1, k), 0, "R2", 0);
    for (int k = 0; k < 16; k++)
      for (int b = 0; b < 6; b++)
        query(addr_of(1, k) ^ (48'h80 << (8*b)), 0, "R5", 0);
    query(addr_of(1, 4) ^ 48'h1, 1, "R8", 0);
    query({8'hA5^8'd2, 8'hA5^8'd3, 8'hA5^8'd6, 8'hA5^8'd7, 8'hA5^8'd10, 8'hA5^8'd11},
          0, "R3", 0);

    send_setup(2, 192, 3, 192);
    for (int k = 0; k < 16; k++) query(addr_of(2, k), 0, "R7", 0);
    for (int k = 0; k < 4; k++) query(addr_of(3, k), 0, "R7", 0);
    query(addr_of(1, 0), 0, "R5", 0);

    send_setup(3, 100, 0, 0);
    for (int k = 0; k < 16; k += 3) query(addr_of(2, k), 0, "R6", 0);
    for (int k = 0; k < 8; k++) query(addr_of(3, k), 0, "R6", 0);
    send_setup(3, 150, 0, 0);
    send_setup(1, 192, 0, 0);
    for (int k = 0; k < 16; k += 5) query(addr_of(1, k), 0, "R6", 0);

    query(addr_of(1, 2), 0, "R9", 4);
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      da_valid = 1; da_start = (b == 0); da_byte = 8'hEE;
    end
    query(addr_of(1, 6), 0, "R9", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule